// File: doc/BRIEF.md
# LRU Stack-Depth Hit Profiler

This block watches a stream of cache line addresses and measures, in one pass, how many hits a cache of each associativity from one way up to `WAYS` ways would have scored, all with the same set count. For each set it keeps a small directory of tags ordered by recency of use, and it updates that directory under true least-recently-used replacement. When an access finds its tag in the directory, the block notes how deep in the recency order the tag sat and adds one to the counter for that depth. When the tag is absent, it adds one to a miss counter instead.

The low `$clog2(SETS)` bits of the address select the set, and the remaining upper bits form the tag. Because replacement is LRU, a cache with k ways would hit exactly on the accesses found at depths 0 to k-1. A query port therefore returns the sum of the first k depth counters for any chosen k. All counters saturate. A synchronous clear empties every directory and zeroes every counter. Data storage and write behaviour are not modelled.

Top module: `lru_depth_profiler`

## Requirements
- R1: After reset, or after a cycle with `clr` high, every depth counter and the miss counter read 0, and every directory is empty, so the next access to any address counts as a miss.
- R2: An access (`acc_vld` high) whose tag is not in its set's directory adds 1 to `miss_cnt` and leaves every depth counter unchanged. An access never changes more than one counter.
- R3: An access whose tag sits at depth i of its set's directory adds 1 to depth counter i only. Depth 0 is the most recently used entry, and depth counter i occupies `depth_cnt[i*CNT_W +: CNT_W]`.
- R4: After a hit at depth i, the hit tag moves to depth 0, the entries at depths 0 to i-1 move one place deeper, and deeper entries keep their places.
- R5: After a miss, the new tag enters at depth 0, every valid entry moves one place deeper, and the entry at depth WAYS-1 is dropped. An access to a dropped tag is a miss.
- R6: The set index is `acc_addr[$clog2(SETS)-1:0]`, and accesses to one set leave the directories of the other sets unchanged.
- R7: Each counter stops at 2^CNT_W-1 and does not wrap.
- R8: `qry_sum` equals the sum of depth counters 0 to `qry_k`-1. It is 0 when `qry_k` is 0 and the sum of all counters when `qry_k` is WAYS or larger. It follows the counters combinationally.
- R9: In a cycle with `acc_vld` low and `clr` low, no counter or directory changes, whatever `acc_addr` carries.
- R10: Empty directory entries never match, including a tag value of 0.
- R11: When `clr` and `acc_vld` are both high in the same cycle, the clear takes effect and the access is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters and directories |
| acc_vld | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Line address: set index in the low bits, tag above |
| qry_k | input | $clog2(WAYS+1) | Associativity to query |
| depth_cnt | output | WAYS*CNT_W | Saturating hit counters, one per depth |
| miss_cnt | output | CNT_W | Saturating miss counter |
| qry_sum | output | CNT_W+$clog2(WAYS) | Hits for a `qry_k`-way cache |

## Verification
A wrong recency order stays hidden until a later access reaches the misordered entry. When that happens, the access adds to the wrong depth counter, or it misses where it should hit. The bench therefore drives access sequences of known hit depths and reads the counters after every single access, so that a fault shows up at the first access that reveals it. A bad eviction appears as a missing miss when the dropped line is accessed again. A set-selection fault appears as a wrong depth after accesses to other sets are interleaved. A slip in the query summation shows up directly in `qry_sum` for some k.

// File: rtl/lrup_pkg.sv
package lrup_pkg;
   // index width that never collapses to zero bits
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lrup_match.sv
module lrup_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   localparam int WAY_W = lrup_pkg::idx_w(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            vld,
   input  logic [TAG_W-1:0]           tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_pos
);
   always_comb begin
      hit     = 1'b0;
      hit_pos = '0;
      for (int i = WAYS-1; i >= 0; i--) begin
         if (vld[i] && (tags[i] == tag)) begin
            hit     = 1'b1;
            hit_pos = WAY_W'(i);
         end
      end
   end
endmodule

// File: rtl/lrup_reorder.sv
module lrup_reorder #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   localparam int WAY_W = lrup_pkg::idx_w(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            vld,
   input  logic [TAG_W-1:0]           tag,
   input  logic                       hit,
   input  logic [WAY_W-1:0]           hit_pos,
   output logic [WAYS-1:0][TAG_W-1:0] nxt_tags,
   output logic [WAYS-1:0]            nxt_vld
);
   always_comb begin
      nxt_tags[0] = tag;
      nxt_vld[0]  = 1'b1;
      for (int j = 1; j < WAYS; j++) begin
         if (!hit || (WAY_W'(j) <= hit_pos)) begin
            nxt_tags[j] = tags[j-1];
            nxt_vld[j]  = vld[j-1];
         end else begin
            nxt_tags[j] = tags[j];
            nxt_vld[j]  = vld[j];
         end
      end
   end
endmodule

// File: rtl/lrup_sat_cnt.sv
module lrup_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clr)                cnt <= '0;
      else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lru_depth_profiler.sv
module lru_depth_profiler #(
   parameter int WAYS   = 4,
   parameter int SETS   = 16,
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16,
   localparam int IDX_B = $clog2(SETS),
   localparam int SET_W = lrup_pkg::idx_w(SETS),
   localparam int WAY_W = lrup_pkg::idx_w(WAYS),
   localparam int TAG_W = ADDR_W - IDX_B,
   localparam int K_W   = $clog2(WAYS+1),
   localparam int SUM_W = CNT_W + $clog2(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  acc_vld,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [K_W-1:0]        qry_k,
   output logic [WAYS*CNT_W-1:0] depth_cnt,
   output logic [CNT_W-1:0]      miss_cnt,
   output logic [SUM_W-1:0]      qry_sum
);
   // elaboration-time parameter checks
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be 2 or more");
   end
   if ((1 << IDX_B) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the set index width");
   end

   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] dir_tag;
   logic [SETS-1:0][WAYS-1:0]            dir_vld;
   logic [SET_W-1:0]                     set_idx;
   logic [TAG_W-1:0]                     acc_tag;

   if (IDX_B == 0) begin : g_one_set
      assign set_idx = '0;
   end else begin : g_many_sets
      assign set_idx = acc_addr[IDX_B-1:0];
   end
   assign acc_tag = acc_addr[ADDR_W-1:IDX_B];

   logic                         hit;
   logic [WAY_W-1:0]             hit_pos;
   logic [WAYS-1:0][TAG_W-1:0]   nxt_tags;
   logic [WAYS-1:0]              nxt_vld;

   lrup_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .tags    (dir_tag[set_idx]),
      .vld     (dir_vld[set_idx]),
      .tag     (acc_tag),
      .hit     (hit),
      .hit_pos (hit_pos)
   );

   lrup_reorder #(.WAYS(WAYS), .TAG_W(TAG_W)) u_reorder (
      .tags     (dir_tag[set_idx]),
      .vld      (dir_vld[set_idx]),
      .tag      (acc_tag),
      .hit      (hit),
      .hit_pos  (hit_pos),
      .nxt_tags (nxt_tags),
      .nxt_vld  (nxt_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_tag <= '0;
         dir_vld <= '0;
      end else if (clr) begin
         dir_tag <= '0;
         dir_vld <= '0;
      end else if (acc_vld) begin
         dir_tag[set_idx] <= nxt_tags;
         dir_vld[set_idx] <= nxt_vld;
      end
   end

   // one saturating counter per directory depth
   for (genvar d = 0; d < WAYS; d++) begin : g_depth
      logic inc_d;
      assign inc_d = acc_vld && hit && (hit_pos == WAY_W'(d));
      lrup_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .inc   (inc_d),
         .cnt   (depth_cnt[d*CNT_W +: CNT_W])
      );
   end

   lrup_sat_cnt #(.W(CNT_W)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (acc_vld && !hit),
      .cnt   (miss_cnt)
   );

   // hits of a qry_k-way cache: prefix sum of the depth histogram
   always_comb begin
      qry_sum = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (K_W'(i) < qry_k)
            qry_sum = qry_sum + SUM_W'(depth_cnt[i*CNT_W +: CNT_W]);
      end
   end
endmodule

// File: rtl/lrup_prof_chk.sv
module lrup_prof_chk #(
   parameter int WAYS  = 4,
   parameter int CNT_W = 16,
   localparam int K_W   = $clog2(WAYS+1),
   localparam int SUM_W = CNT_W + $clog2(WAYS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  clr,
   input logic                  acc_vld,
   input logic [K_W-1:0]        qry_k,
   input logic [WAYS*CNT_W-1:0] depth_cnt,
   input logic [CNT_W-1:0]      miss_cnt,
   input logic [SUM_W-1:0]      qry_sum
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [WAYS*CNT_W-1:0] prv_depth;
   logic [CNT_W-1:0]      prv_miss;
   logic [WAYS:0]         chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_depth <= '0;
         prv_miss  <= '0;
      end else begin
         prv_depth <= depth_cnt;
         prv_miss  <= miss_cnt;
      end
   end

   always_comb begin
      chg[WAYS] = (miss_cnt != prv_miss);
      for (int i = 0; i < WAYS; i++)
         chg[i] = (depth_cnt[i*CNT_W +: CNT_W] != prv_depth[i*CNT_W +: CNT_W]);
   end

   // R2
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> $onehot0(chg));

   // R9
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(acc_vld) && !$past(clr)) |-> ($stable(depth_cnt) && $stable(miss_cnt)));

   // R11
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (depth_cnt == '0 && miss_cnt == '0));

   // R7
   miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(miss_cnt) == TOP && !$past(clr)) |-> (miss_cnt == TOP));

   // R8
   qry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_k == '0) |-> (qry_sum == '0));

   // R3
   for (genvar d = 0; d < WAYS; d++) begin : g_mono
      no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(clr) |-> (depth_cnt[d*CNT_W +: CNT_W] >= $past(depth_cnt[d*CNT_W +: CNT_W])));
   end
endmodule

bind lru_depth_profiler lrup_prof_chk #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .acc_vld   (acc_vld),
   .qry_k     (qry_k),
   .depth_cnt (depth_cnt),
   .miss_cnt  (miss_cnt),
   .qry_sum   (qry_sum)
);

// File: tb/lru_depth_profiler_tb.sv
module lru_depth_profiler_tb;
   localparam int WAYS = 4, SETS = 4, ADDR_W = 12, CNT_W = 4;
   localparam int K_W = $clog2(WAYS+1), SUM_W = CNT_W + $clog2(WAYS);

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  clr = 1'b0;
   logic                  acc_vld = 1'b0;
   logic [ADDR_W-1:0]     acc_addr = '0;
   logic [K_W-1:0]        qry_k = '0;
   logic [WAYS*CNT_W-1:0] depth_cnt;
   logic [CNT_W-1:0]      miss_cnt;
   logic [SUM_W-1:0]      qry_sum;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   lru_depth_profiler #(.WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .acc_vld(acc_vld), .acc_addr(acc_addr),
      .qry_k(qry_k), .depth_cnt(depth_cnt), .miss_cnt(miss_cnt), .qry_sum(qry_sum)
   );

   function automatic logic [ADDR_W-1:0] la(input int tag, input int set);
      return {10'(tag), 2'(set)};
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   // compare all counters: depth 0..3 then miss
   task automatic chk_all(input string req, input int e0, input int e1,
                          input int e2, input int e3, input int em);
      chk({req, " d0"}, int'(depth_cnt[0*CNT_W +: CNT_W]), e0);
      chk({req, " d1"}, int'(depth_cnt[1*CNT_W +: CNT_W]), e1);
      chk({req, " d2"}, int'(depth_cnt[2*CNT_W +: CNT_W]), e2);
      chk({req, " d3"}, int'(depth_cnt[3*CNT_W +: CNT_W]), e3);
      chk({req, " miss"}, int'(miss_cnt), em);
   endtask

   task automatic acc(input logic [ADDR_W-1:0] a);
      @(negedge clk);
      acc_vld  = 1'b1;
      acc_addr = a;
      @(negedge clk);
      acc_vld  = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic t_reset();
      qry_k = 3'd4;
      @(negedge clk);
      chk_all("R1 reset", 0, 0, 0, 0, 0);
      chk("R1 reset qry", int'(qry_sum), 0);
   endtask

   task automatic t_cold();
      do_clr();
      acc(la(0, 0));   // tag 0 in an empty directory
      chk_all("R10 zero tag miss", 0, 0, 0, 0, 1);
      acc(la(0, 0));
      chk_all("R3 depth0 hit", 1, 0, 0, 0, 1);
   endtask

   task automatic t_depth();
      do_clr();
      for (int t = 1; t <= 4; t++) acc(la(t, 0));
      chk_all("R2 four misses", 0, 0, 0, 0, 4);
      acc(la(1, 0));   // order 4,3,2,1 -> tag1 at depth 3
      chk_all("R3 depth3", 0, 0, 0, 1, 4);
      acc(la(3, 0));   // order 1,4,3,2 -> depth 2
      chk_all("R4 depth2", 0, 0, 1, 1, 4);
      acc(la(1, 0));   // order 3,1,4,2 -> depth 1
      chk_all("R4 depth1", 0, 1, 1, 1, 4);
      acc(la(1, 0));   // order 1,3,4,2 -> depth 0
      chk_all("R4 depth0", 1, 1, 1, 1, 4);
      acc(la(2, 0));   // tag2 kept at depth 3
      chk_all("R4 deep kept", 1, 1, 1, 2, 4);
   endtask

   task automatic t_query();
      // counters now d0=1 d1=1 d2=1 d3=2
      int exp_q[8] = '{0, 1, 2, 3, 5, 5, 5, 5};
      for (int k = 0; k < 8; k++) begin
         qry_k = 3'(k);
         #1;
         chk("R8 qry_sum", int'(qry_sum), exp_q[k]);
      end
      qry_k = 3'd4;
   endtask

   task automatic t_evict();
      do_clr();
      for (int t = 1; t <= 5; t++) acc(la(t, 1));
      chk_all("R5 five misses", 0, 0, 0, 0, 5);
      acc(la(1, 1));   // dropped -> miss; order 1,5,4,3
      chk_all("R5 evicted miss", 0, 0, 0, 0, 6);
      acc(la(2, 1));   // also gone; order 2,1,5,4
      acc(la(5, 1));   // depth 2
      chk_all("R5 shift after miss", 0, 0, 1, 0, 7);
   endtask

   task automatic t_sets();
      do_clr();
      acc(la(7, 0));
      acc(la(7, 2));   // same tag, other set: miss
      acc(la(8, 3));
      acc(la(9, 1));
      acc(la(7, 0));   // still depth 0 in set 0
      chk_all("R6 set independence", 1, 0, 0, 0, 4);
   endtask

   task automatic t_idle();
      do_clr();
      acc(la(3, 2));
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         acc_addr = la(i + 20, i);
      end
      @(negedge clk);
      chk_all("R9 idle no change", 0, 0, 0, 0, 1);
      acc(la(3, 2));
      chk_all("R9 directory kept", 1, 0, 0, 0, 1);
   endtask

   task automatic t_clr_pri();
      acc(la(3, 2));
      @(negedge clk);
      clr = 1'b1; acc_vld = 1'b1; acc_addr = la(3, 2);
      @(negedge clk);
      clr = 1'b0; acc_vld = 1'b0;
      chk_all("R11 clear wins", 0, 0, 0, 0, 0);
      acc(la(3, 2));
      chk_all("R1 directory emptied", 0, 0, 0, 0, 1);
   endtask

   task automatic t_sat();
      do_clr();
      acc(la(4, 3));
      for (int i = 0; i < 20; i++) acc(la(4, 3));
      chk_all("R7 hit saturate", 15, 0, 0, 0, 1);
      for (int i = 0; i < 20; i++) acc(la(100 + i, 3));
      chk_all("R7 miss saturate", 15, 0, 0, 0, 15);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold();
      t_depth();
      t_query();
      t_evict();
      t_sets();
      t_idle();
      t_clr_pri();
      t_sat();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule